// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This peripheral guards a system against software that stops running. Software arms it by setting an enable bit in a control register and choosing a timeout in half-second units. From then on a down-counter advances on every pulse of a slow half-second tick-enable input. Software keeps the system alive by writing a fixed pair of key words, in order, to a service register, which restarts the count. If the count runs out, the block issues a one-cycle system reset pulse and records in a read-only status register that the last reset was a watchdog expiry.

The enable bit is sticky. Once set, software cannot clear it. Only the external power-on reset or an expiry of the watchdog clears it. Two stop bits let the count freeze while the chip is in a low-power state or halted by a debugger. Three 16-bit registers sit on a simple single-cycle write bus with a combinational read port, at byte offsets 0 (control), 2 (service) and 4 (status).

Top module: `kwd_timer`

## Requirements
- R1: Control is at offset 0, service at offset 2 and status at offset 4. Control bits 0, 1, 2, 3, 7 and 15:8 are writable and read back. Control bits 6:4 read 0, and the service register always reads 0.
- R2: The enable bit (control bit 2) is sticky. Writing 0 to it after it is set leaves it at 1, while the other writable control bits still take the new value. Only the reset input or a watchdog expiry clears it.
- R3: With timeout field WT in control bits 15:8, a valid service sequence makes the reset pulse appear exactly WT+1 tick pulses later, on the clock cycle after the edge that takes the last tick.
- R4: A reload happens only when two consecutive service writes carry 0x5555 and then 0xAAAA. Any other service write returns the matcher to idle, and this includes a second 0x5555. A lone 0xAAAA does not reload.
- R5: The write that first sets the enable bit loads the counter with the WT value carried in that same write, plus one.
- R6: Writing a new WT while the count runs leaves the count in progress unchanged. The new value is used at the next valid service sequence.
- R7: While enabled, the count holds when low-power stop is high and control bit 0 is set, or when debug stop is high and control bit 1 is set. A stop input whose control bit is clear has no effect.
- R8: The reset pulse lasts one cycle. In the same cycle the status register becomes 0x0001 (bit 0 = watchdog expiry), and control is back to 0 with the count stopped.
- R9: After the reset input, status reads 0x0002 (bit 1 = power-on) and control reads 0. Writes to the status offset are ignored.
- R10: While the enable bit is clear, tick pulses never produce a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| half_tick | input | 1 | One-cycle pulse every half second |
| lowpwr_stop | input | 1 | Chip is in a low-power state |
| debug_stop | input | 1 | Chip is halted by a debugger |
| wdog_rst_pulse | output | 1 | One-cycle system reset request on expiry |

## Verification
The hardest states to reach are the ones in the middle of a count: a count that is partly used up when a wrong key word arrives, a new timeout value arrives, or a stop input rises. The counter itself cannot be seen at the ports. The stimulus therefore gives a known number of ticks first, applies the disturbing write or stop, and then counts ticks until the reset pulse. The remainder shows whether the count was reloaded, kept or frozen. A sweep over many timeout values compares each expiry distance with WT+1.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int CTL_LP_BIT  = 0;
   localparam int CTL_DBG_BIT = 1;
   localparam int CTL_EN_BIT  = 2;
   localparam int CTL_OUT_BIT = 3;
   localparam int CTL_AUX_BIT = 7;
   localparam int STAT_TO_BIT  = 0;
   localparam int STAT_POR_BIT = 1;
   localparam int OFF_CTL  = 0;
   localparam int OFF_SVC  = 2;
   localparam int OFF_STAT = 4;
   typedef enum logic {KEY_IDLE = 1'b0, KEY_ARMED = 1'b1} key_st_e;
endpackage

// File: rtl/kwd_ctrl_reg.sv
module kwd_ctrl_reg
   import kwd_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int WT_LSB = 8,
   parameter int WT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clr,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              en_load,
   output logic [WT_W-1:0]   wt_new
);
   localparam logic [DATA_W-1:0] WT_MASK  = DATA_W'(((1 << WT_W) - 1) << WT_LSB);
   localparam logic [DATA_W-1:0] BIT_MASK = DATA_W'((1 << CTL_LP_BIT) | (1 << CTL_DBG_BIT) |
                                                    (1 << CTL_EN_BIT) | (1 << CTL_OUT_BIT) |
                                                    (1 << CTL_AUX_BIT));
   localparam logic [DATA_W-1:0] WR_MASK  = WT_MASK | BIT_MASK;
   localparam logic [DATA_W-1:0] EN_MASK  = DATA_W'(1 << CTL_EN_BIT);

   assign wt_new  = wdata[WT_LSB +: WT_W];
   assign en_load = wr_en & ~clr & ~ctrl_q[CTL_EN_BIT] & wdata[CTL_EN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (clr)   ctrl_q <= '0;
      else if (wr_en) ctrl_q <= (wdata & WR_MASK) | (ctrl_q & EN_MASK);
   end
endmodule

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
   import kwd_pkg::*;
#(
   parameter int                DATA_W = 16,
   parameter logic [DATA_W-1:0] KEY_A  = 16'h5555,
   parameter logic [DATA_W-1:0] KEY_B  = 16'hAAAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              svc_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clr,
   output logic              reload
);
   key_st_e st_q, st_d;

   assign reload = svc_wr & ~clr & (st_q == KEY_ARMED) & (wdata == KEY_B);

   always_comb begin
      st_d = st_q;
      if (clr)
         st_d = KEY_IDLE;
      else if (svc_wr)
         st_d = (st_q == KEY_IDLE && wdata == KEY_A) ? KEY_ARMED : KEY_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KEY_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             hold,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic step;
   assign step   = run & tick & ~hold & ~load;
   assign expire = step & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (expire) cnt_q <= '0;
      else if (load)   cnt_q <= load_val;
      else if (step)   cnt_q <= cnt_q - LAST;
   end
endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
   import kwd_pkg::*;
#(
   parameter int                DATA_W = 16,
   parameter int                ADDR_W = 3,
   parameter int                WT_LSB = 8,
   parameter int                WT_W   = 8,
   parameter logic [DATA_W-1:0] KEY_A  = 16'h5555,
   parameter logic [DATA_W-1:0] KEY_B  = 16'hAAAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              half_tick,
   input  logic              lowpwr_stop,
   input  logic              debug_stop,
   output logic              wdog_rst_pulse
);
   localparam int CNT_W = WT_W + 1;
   localparam logic [DATA_W-1:0] STAT_POR = DATA_W'(1 << STAT_POR_BIT);
   localparam logic [DATA_W-1:0] STAT_TO  = DATA_W'(1 << STAT_TO_BIT);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
   localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(OFF_SVC);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

   if (WT_LSB + WT_W > DATA_W) begin : g_bad_wt
      $error("timeout field does not fit in the data width");
   end
   if (WT_LSB <= CTL_AUX_BIT) begin : g_bad_lsb
      $error("timeout field overlaps the mode bits");
   end
   if ((1 << ADDR_W) <= OFF_STAT) begin : g_bad_addr
      $error("address width too small for the register map");
   end
   if (KEY_A == KEY_B) begin : g_bad_key
      $error("service keys must differ");
   end

   logic              wr_ctl, wr_svc;
   logic [DATA_W-1:0] ctrl_q, stat_q;
   logic              en_load, reload, load, expire, hold, ctrl_en;
   logic [WT_W-1:0]   wt_new;
   logic [CNT_W-1:0]  load_val, cnt_q;

   assign wr_ctl  = bus_sel & bus_we & (bus_addr == A_CTL);
   assign wr_svc  = bus_sel & bus_we & (bus_addr == A_SVC);
   assign ctrl_en = ctrl_q[CTL_EN_BIT];
   assign hold    = (lowpwr_stop & ctrl_q[CTL_LP_BIT]) | (debug_stop & ctrl_q[CTL_DBG_BIT]);
   assign load    = en_load | reload;
   assign load_val = en_load ? (CNT_W'(wt_new) + CNT_W'(1))
                             : (CNT_W'(ctrl_q[WT_LSB +: WT_W]) + CNT_W'(1));

   kwd_ctrl_reg #(.DATA_W(DATA_W), .WT_LSB(WT_LSB), .WT_W(WT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctl), .wdata(bus_wdata), .clr(expire),
      .ctrl_q(ctrl_q), .en_load(en_load), .wt_new(wt_new));

   kwd_key_seq #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
      .clk(clk), .rst_n(rst_n), .svc_wr(wr_svc), .wdata(bus_wdata), .clr(expire),
      .reload(reload));

   kwd_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(ctrl_en), .tick(half_tick), .hold(hold),
      .load(load), .load_val(load_val), .expire(expire), .cnt_q(cnt_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q         <= STAT_POR;
         wdog_rst_pulse <= 1'b0;
      end else begin
         wdog_rst_pulse <= expire;
         if (expire) stat_q <= STAT_TO;
      end
   end

   always_comb begin
      case (bus_addr)
         A_CTL:   bus_rdata = ctrl_q;
         A_STAT:  bus_rdata = stat_q;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/kwd_timer_chk.sv
module kwd_timer_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wdog_rst_pulse,
   input logic              ctrl_en,
   input logic              expire,
   input logic              hold,
   input logic              load,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [DATA_W-1:0] stat_q
);
   // R8: reset request never lasts two cycles
   a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_pulse |=> !wdog_rst_pulse);
   // R8: status shows only the expiry cause while the pulse is out
   a_r8_status_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_pulse |-> (stat_q[0] && !stat_q[1]));
   // R2: enable stays set unless the watchdog expires
   a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && !expire) |=> ctrl_en);
   // R10: no reset request follows a disabled cycle
   a_r10_no_pulse_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> !wdog_rst_pulse);
   // R7: a matching stop freezes the count
   a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && hold && !load) |=> $stable(cnt_q));
endmodule

bind kwd_timer kwd_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wdog_rst_pulse(wdog_rst_pulse), .ctrl_en(ctrl_en),
   .expire(expire), .hold(hold), .load(load), .cnt_q(cnt_q), .stat_q(stat_q));

// File: tb/kwd_timer_tb.sv
module kwd_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        half_tick = 1'b0, lowpwr_stop = 1'b0, debug_stop = 1'b0;
   logic        wdog_rst_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4ns clk = ~clk;

   kwd_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .half_tick(half_tick),
      .lowpwr_stop(lowpwr_stop), .debug_stop(debug_stop), .wdog_rst_pulse(wdog_rst_pulse));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = int'(bus_rdata);
   endtask

   task automatic service();
      wr(3'd2, 16'h5555);
      wr(3'd2, 16'hAAAA);
   endtask

   task automatic tick_once(output bit seen);
      @(negedge clk);
      half_tick = 1'b1;
      @(negedge clk);
      half_tick = 1'b0;
      seen = wdog_rst_pulse;
   endtask

   // ticks given until the reset pulse shows, 0 if none within limit
   task automatic count_ticks(input int limit, output int n);
      bit seen;
      n = 0;
      for (int i = 1; i <= limit; i++) begin
         tick_once(seen);
         if (seen) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic quiet_ticks(input int k, output int pulses);
      bit seen;
      pulses = 0;
      for (int i = 0; i < k; i++) begin
         tick_once(seen);
         if (seen) pulses++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8ns * 190000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int v, n, p;
      bit seen;
      do_reset();

      // R9 / R1 reset state
      rd(3'd0, v); chk("R9 ctrl after reset", v, 0);
      rd(3'd4, v); chk("R9 status after reset", v, 16'h0002);
      rd(3'd2, v); chk("R1 service reads zero", v, 0);
      wr(3'd4, 16'hFFFF);
      rd(3'd4, v); chk("R9 status write ignored", v, 16'h0002);

      // R10 disabled ticks
      quiet_ticks(10, p); chk("R10 no pulse while disabled", p, 0);

      // R1 writable mask, R2 sticky enable
      wr(3'd0, 16'hFFFF);
      rd(3'd0, v); chk("R1 control mask", v, 16'hFF8F);
      wr(3'd0, 16'h0000);
      rd(3'd0, v); chk("R2 enable sticky on zero write", v, 16'h0004);
      wr(3'd0, 16'hFB00);
      rd(3'd0, v); chk("R2 other bits still written", v, 16'hFB04);
      do_reset();
      rd(3'd0, v); chk("R2 reset clears enable", v, 0);

      // R3 sweep over WT
      for (int wt = 0; wt < 66; wt++) begin
         int w;
         w = (wt < 64) ? wt : ((wt == 64) ? 127 : 255);
         wr(3'd0, 16'((w << 8) | 4));
         service();
         count_ticks(300, n);
         chk($sformatf("R3 expiry distance WT=%0d", w), n, w + 1);
         if (wt == 0 || wt == 65) begin
            @(negedge clk);
            chk("R8 pulse one cycle", int'(wdog_rst_pulse), 0);
            rd(3'd4, v); chk("R8 status expiry", v, 16'h0001);
            rd(3'd0, v); chk("R8 control cleared", v, 0);
            quiet_ticks(3, p); chk("R8 count stopped after expiry", p, 0);
         end
      end

      // R5 enable write loads count
      wr(3'd0, 16'h0304);
      count_ticks(50, n); chk("R5 load on enable", n, 4);

      // R4 key sequence corner cases (WT=5 -> 6 ticks)
      wr(3'd0, 16'h0504); quiet_ticks(2, p);
      wr(3'd2, 16'hAAAA);
      count_ticks(50, n); chk("R4 lone second key no reload", n, 4);
      wr(3'd0, 16'h0504); quiet_ticks(2, p);
      wr(3'd2, 16'h5555); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
      count_ticks(50, n); chk("R4 doubled first key no reload", n, 4);
      wr(3'd0, 16'h0504); quiet_ticks(2, p);
      wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
      count_ticks(50, n); chk("R4 interrupted sequence no reload", n, 4);
      wr(3'd0, 16'h0504); quiet_ticks(2, p);
      service();
      count_ticks(50, n); chk("R4 valid sequence reloads", n, 6);

      // R6 live WT change
      wr(3'd0, 16'h0504); quiet_ticks(2, p);
      wr(3'd0, 16'h0104);
      count_ticks(50, n); chk("R6 count in progress kept", n, 4);
      wr(3'd0, 16'h0504); quiet_ticks(1, p);
      wr(3'd0, 16'h0104);
      service();
      count_ticks(50, n); chk("R6 new WT at service", n, 2);

      // R7 stop inputs
      wr(3'd0, 16'h0305);
      lowpwr_stop = 1'b1;
      quiet_ticks(6, p); chk("R7 low-power freeze", p, 0);
      lowpwr_stop = 1'b0;
      count_ticks(50, n); chk("R7 resume after low-power", n, 4);
      wr(3'd0, 16'h0306);
      debug_stop = 1'b1;
      quiet_ticks(6, p); chk("R7 debug freeze", p, 0);
      debug_stop = 1'b0;
      count_ticks(50, n); chk("R7 resume after debug", n, 4);
      wr(3'd0, 16'h0304);
      lowpwr_stop = 1'b1; debug_stop = 1'b1;
      count_ticks(50, n); chk("R7 stop without bit ignored", n, 4);
      lowpwr_stop = 1'b0; debug_stop = 1'b0;

      // R9 status kept until power-on reset
      rd(3'd4, v); chk("R9 status holds expiry", v, 16'h0001);
      do_reset();
      rd(3'd4, v); chk("R9 status back to power-on", v, 16'h0002);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule